// File: doc/BRIEF.md
# Product-Term Logic Macrocell

This block is one logic cell of a register-based programmable fabric. A product-term array outside the cell delivers up to sixteen terms, and a per-term enable mask gates them before they are ORed into a sum. An XOR stage then combines that sum with a second operand chosen from four sources. The sources are constant 0, constant 1, a local carry, and the cell's own register output. With the register output chosen, the cell behaves as a toggle register.

A small carry path lets neighbouring cells be chained. Two dedicated product terms enter a 2:1 selector. That selector is steered by the incoming carry after a per-cell chain enable has gated it. The selector output leaves as the carry-out and is also offered locally to the XOR stage.

The storage element has the following controls:
- Its clock comes from one of four global clocks or from a product-term clock.
- It can capture on either edge of that clock.
- It has an asynchronous set and an asynchronous clear. Each is sourced from one of two polarity-programmable control terms, or is held off.

An output selector presents either the registered value or the XOR result. Every configuration input is meant to stay static during operation.

Top module: `pterm_macrocell`

## Requirements
- R1: The sum is 1 exactly when some bit of `pt_in & pt_mask` is 1. A masked-off term never contributes.
- R2: The effective carry is `carry_in & chain_en`. `carry_out` equals `cpt[1]` when the effective carry is 1, and `cpt[0]` otherwise. The same value is the local carry.
- R3: With `chain_en` = 0, `carry_in` has no effect on `carry_out` or `mc_out`.
- R4: The XOR operand is selected by `xor_sel`: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives the local carry, and 2'b11 gives the register output. In combinational mode, `mc_out` is the sum XOR that operand.
- R5: With `xor_sel` = 2'b11, the register inverts on each active edge while the sum is 1, and holds while the sum is 0. Two cells can form a binary counter.
- R6: `clk_sel` values 0 to 3 clock the register from `gclk[0]` to `gclk[3]`. Values 4 to 7 all select `pt_clk`.
- R7: With `clk_fall` = 1, the register captures on the falling edge of the selected clock and ignores its rising edge. With `clk_fall` = 0, the reverse holds.
- R8: `set_src` and `clr_src` each choose a source: 2'b01 is control term 0, 2'b10 is control term 1, and 2'b00 or 2'b11 means never active. An active set forces the register to 1 and an active clear forces it to 0, both without a clock edge.
- R9: Control term i is active when `prc[i] ^ prc_inv[i]` is 1.
- R10: When set and clear are both active, the register reads 0.
- R11: `comb_mode` = 1 drives `mc_out` from the XOR result. `comb_mode` = 0 drives it from the register.
- R12: With `xor_sel` = 2'b00 in registered mode, the register takes the sum on each active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | NGCLK | Global clocks |
| pt_clk | input | 1 | Product-term clock |
| pt_in | input | NPT | Product-term inputs from the array |
| pt_mask | input | NPT | Per-term enable mask |
| cpt | input | 2 | Dedicated carry product terms |
| carry_in | input | 1 | Carry from the previous cell |
| chain_en | input | 1 | Chain enable; 0 cuts the incoming carry |
| xor_sel | input | 2 | XOR operand select |
| clk_sel | input | CSW | Register clock select |
| clk_fall | input | 1 | 1 selects falling-edge capture |
| prc | input | 2 | Set/clear control terms |
| prc_inv | input | 2 | Polarity of each control term |
| set_src | input | 2 | Source of asynchronous set |
| clr_src | input | 2 | Source of asynchronous clear |
| comb_mode | input | 1 | 1 selects the combinational output |
| carry_out | output | 1 | Carry to the next cell |
| mc_out | output | 1 | Cell output |

## Verification
The sum is exercised with three patterns:
- active terms that are masked off;
- a single unmasked term;
- an all-ones input under an all-zero mask.

Together these separate the gating from the OR. Two chained cells are wired as a two-bit adder slice and driven with all 32 combinations of operands and carry-in. This shows whether the carry selector, the local carry and the XOR stage agree; cutting the chain in that setup shows the carry being ignored. Toggle counting, capture on both edges, each clock source, and every set/clear and polarity combination each isolate one register control.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    XOP_ZERO     = 2'b00,
    XOP_ONE      = 2'b01,
    XOP_CARRY    = 2'b10,
    XOP_FEEDBACK = 2'b11
  } xop_e;

  typedef enum logic [1:0] {
    ASRC_OFF0 = 2'b00,
    ASRC_T0   = 2'b01,
    ASRC_T1   = 2'b10,
    ASRC_OFF1 = 2'b11
  } asrc_e;

  // Second XOR operand chosen by the select field
  function automatic logic xop_pick(input xop_e sel, input logic lc, input logic q);
    logic r;
    case (sel)
      XOP_ZERO:  r = 1'b0;
      XOP_ONE:   r = 1'b1;
      XOP_CARRY: r = lc;
      default:   r = q;
    endcase
    return r;
  endfunction

  // Resolve one asynchronous control from the two polarity-corrected terms
  function automatic logic asrc_pick(input asrc_e src, input logic [1:0] act);
    logic r;
    case (src)
      ASRC_T0: r = act[0];
      ASRC_T1: r = act[1];
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pmc_sum_carry.sv
module pmc_sum_carry #(
  parameter int NPT = 16
) (
  input  logic [NPT-1:0] pt_in,
  input  logic [NPT-1:0] pt_mask,
  input  logic [1:0]     cpt,
  input  logic           carry_in,
  input  logic           chain_en,
  output logic           sum_o,
  output logic           lc_o,
  output logic           cin_eff_o
);
  logic [NPT-1:0] live_terms;

  assign live_terms = pt_in & pt_mask;
  assign sum_o      = |live_terms;
  assign cin_eff_o  = carry_in & chain_en;
  assign lc_o       = cin_eff_o ? cpt[1] : cpt[0];
endmodule

// File: rtl/pmc_clk_pick.sv
module pmc_clk_pick #(
  parameter int NGCLK = 4,
  parameter int CSW   = 3
) (
  input  logic [NGCLK-1:0] gclk,
  input  logic             pt_clk,
  input  logic [CSW-1:0]   clk_sel,
  input  logic             clk_fall,
  output logic             clk_o
);
  logic picked;

  // Any code past the global range falls back to the product-term clock
  always_comb begin
    picked = pt_clk;
    for (int i = 0; i < NGCLK; i++) begin
      if (clk_sel == CSW'(i)) picked = gclk[i];
    end
  end

  // Edge choice by inversion of the chosen clock, never by gating it
  assign clk_o = picked ^ clk_fall;
endmodule

// File: rtl/pmc_async_ctl.sv
module pmc_async_ctl
  import pmc_pkg::*;
(
  input  logic [1:0] prc,
  input  logic [1:0] prc_inv,
  input  logic [1:0] set_src,
  input  logic [1:0] clr_src,
  output logic       set_o,
  output logic       clr_o
);
  logic [1:0] term_act;

  assign term_act = prc ^ prc_inv;
  assign set_o    = asrc_pick(asrc_e'(set_src), term_act);
  assign clr_o    = asrc_pick(asrc_e'(clr_src), term_act);
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell
  import pmc_pkg::*;
#(
  parameter int NPT   = 16,
  parameter int NGCLK = 4,
  parameter int CSW   = 3
) (
  input  logic [NGCLK-1:0] gclk,
  input  logic             pt_clk,
  input  logic [NPT-1:0]   pt_in,
  input  logic [NPT-1:0]   pt_mask,
  input  logic [1:0]       cpt,
  input  logic             carry_in,
  input  logic             chain_en,
  input  logic [1:0]       xor_sel,
  input  logic [CSW-1:0]   clk_sel,
  input  logic             clk_fall,
  input  logic [1:0]       prc,
  input  logic [1:0]       prc_inv,
  input  logic [1:0]       set_src,
  input  logic [1:0]       clr_src,
  input  logic             comb_mode,
  output logic             carry_out,
  output logic             mc_out
);
  logic sum_w, lc_w, cin_eff_w;
  logic clk_eff, set_act, clr_act, rst_any;
  logic xor_res, q_r, async_hit;
  xop_e xop;

  pmc_sum_carry #(.NPT(NPT)) u_sum (
    .pt_in(pt_in), .pt_mask(pt_mask), .cpt(cpt), .carry_in(carry_in),
    .chain_en(chain_en), .sum_o(sum_w), .lc_o(lc_w), .cin_eff_o(cin_eff_w)
  );

  pmc_clk_pick #(.NGCLK(NGCLK), .CSW(CSW)) u_clk (
    .gclk(gclk), .pt_clk(pt_clk), .clk_sel(clk_sel), .clk_fall(clk_fall),
    .clk_o(clk_eff)
  );

  pmc_async_ctl u_actl (
    .prc(prc), .prc_inv(prc_inv), .set_src(set_src), .clr_src(clr_src),
    .set_o(set_act), .clr_o(clr_act)
  );

  assign xop     = xop_e'(xor_sel);
  assign xor_res = sum_w ^ xop_pick(xop, lc_w, q_r);
  assign rst_any = set_act | clr_act;

  // Clear has priority over set
  always_ff @(posedge clk_eff or posedge clr_act or posedge set_act) begin
    if (clr_act)      q_r <= 1'b0;
    else if (set_act) q_r <= 1'b1;
    else              q_r <= xor_res;
  end

  assign carry_out = lc_w;
  assign mc_out    = comb_mode ? xor_res : q_r;

  // Marks an asynchronous override since the last active edge (for checks)
  always_ff @(posedge clk_eff or posedge rst_any) begin
    if (rst_any) async_hit <= 1'b1;
    else         async_hit <= 1'b0;
  end

  assert_clear_wins_R10: assert property (@(posedge clk_eff)
    clr_act |-> (q_r == 1'b0));

  assert_set_forces_R8: assert property (@(posedge clk_eff) disable iff (clr_act)
    set_act |-> (q_r == 1'b1));

  assert_cut_chain_R3: assert property (@(posedge clk_eff) disable iff (rst_any)
    !chain_en |-> (carry_out == cpt[0]));

  assert_d_capture_R12: assert property (@(posedge clk_eff) disable iff (rst_any)
    (xop == XOP_ZERO) |=> (async_hit || q_r == $past(sum_w)));

  assert_toggle_R5: assert property (@(posedge clk_eff) disable iff (rst_any)
    (xop == XOP_FEEDBACK && sum_w) |=> (async_hit || q_r != $past(q_r)));
endmodule

// File: tb/pterm_macrocell_tb.sv
`timescale 1ns/1ps
module pterm_macrocell_tb;
  localparam int NPT = 16, NGCLK = 4, CSW = 3;

  typedef struct {
    int    src;   // 0: low cell out, 1: low cell carry, 2: high cell out
    logic  exp;
    string req;
  } sb_item_t;

  sb_item_t sbq[$];
  event     smp;
  int       checks = 0, errors = 0;
  bit       done = 0;

  logic clk = 0;
  always #2 clk = ~clk;  // 250 MHz

  logic [NGCLK-1:1] gx;
  logic             pt_clk;
  logic [NPT-1:0]   pt_lo, pt_hi_drv, pt_hi, mask;
  logic [1:0]       cpt_lo, cpt_hi, xs_lo, xs_hi;
  logic             cin_lo, chain_lo, chain_hi, hi_fb;
  logic [CSW-1:0]   csel;
  logic             cfall, comb;
  logic [1:0]       prc, pinv, ssrc, csrc;
  logic             lo_out, lo_cout, hi_out, hi_cout;

  assign pt_hi = hi_fb ? {{(NPT-1){1'b0}}, lo_out} : pt_hi_drv;

  pterm_macrocell #(.NPT(NPT), .NGCLK(NGCLK), .CSW(CSW)) u_dut (
    .gclk({gx, clk}), .pt_clk(pt_clk), .pt_in(pt_lo), .pt_mask(mask),
    .cpt(cpt_lo), .carry_in(cin_lo), .chain_en(chain_lo), .xor_sel(xs_lo),
    .clk_sel(csel), .clk_fall(cfall), .prc(prc), .prc_inv(pinv),
    .set_src(ssrc), .clr_src(csrc), .comb_mode(comb),
    .carry_out(lo_cout), .mc_out(lo_out)
  );

  pterm_macrocell #(.NPT(NPT), .NGCLK(NGCLK), .CSW(CSW)) u_dut_hi (
    .gclk({gx, clk}), .pt_clk(pt_clk), .pt_in(pt_hi), .pt_mask(mask),
    .cpt(cpt_hi), .carry_in(lo_cout), .chain_en(chain_hi), .xor_sel(xs_hi),
    .clk_sel(csel), .clk_fall(cfall), .prc(prc), .prc_inv(pinv),
    .set_src(ssrc), .clr_src(csrc), .comb_mode(comb),
    .carry_out(hi_cout), .mc_out(hi_out)
  );

  // Monitor: pops the expected item and compares it with the observed output
  always @(smp) begin
    while (sbq.size() > 0) begin
      sb_item_t it;
      logic act;
      it = sbq.pop_front();
      act = (it.src == 0) ? lo_out : (it.src == 1) ? lo_cout : hi_out;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s src=%0d actual=%b expected=%b", it.req, it.src, act, it.exp);
      end
    end
  end

  task automatic expect_v(input int src, input logic e, input string req);
    sb_item_t it;
    it.src = src; it.exp = e; it.req = req;
    sbq.push_back(it);
    -> smp;
    #0.1;
  endtask

  task automatic tick();
    @(posedge clk); #0.5;
  endtask

  task automatic at_neg();
    @(negedge clk); #0.5;
  endtask

  // Hold both registers cleared through control term 0
  task automatic hold_clear();
    ssrc = 2'b00; csrc = 2'b01; pinv = 2'b00; prc = 2'b01; #0.5;
  endtask

  task automatic drop_clear();
    prc = 2'b00; #0.5;
  endtask

  initial begin
    gx = '0; pt_clk = 0; pt_lo = '0; pt_hi_drv = '0; mask = '1;
    cpt_lo = 2'b00; cpt_hi = 2'b00; xs_lo = 2'b00; xs_hi = 2'b00;
    cin_lo = 0; chain_lo = 0; chain_hi = 0; hi_fb = 0;
    csel = '0; cfall = 0; comb = 0;
    ssrc = 2'b00; csrc = 2'b01; pinv = 2'b00; prc = 2'b01;

    #9;
    expect_v(0, 1'b0, "R10 reset state");
    // Set and clear together: clear wins
    ssrc = 2'b10; prc = 2'b11; #0.5;
    expect_v(0, 1'b0, "R10 set+clear");
    prc = 2'b00; ssrc = 2'b00; csrc = 2'b00; #0.5;

    // R8: set from control term 0
    tick();
    ssrc = 2'b01; prc = 2'b01; #0.5;
    expect_v(0, 1'b1, "R8 async set");
    prc = 2'b00; ssrc = 2'b00;
    tick();
    expect_v(0, 1'b0, "R12 capture after set");

    // R9: inverted term 1 acts as clear when its input is 0
    pt_lo = 16'h0001; tick();
    expect_v(0, 1'b1, "R12 capture 1");
    at_neg();
    csrc = 2'b10; pinv = 2'b10; prc = 2'b10; #0.2;
    expect_v(0, 1'b1, "R9 inverted term inactive");
    prc = 2'b00; #0.2;
    expect_v(0, 1'b0, "R9 inverted term clears");
    prc = 2'b10; csrc = 2'b00; pinv = 2'b00; prc = 2'b00;
    pt_lo = '0;

    // R1, R4, R11 in combinational mode
    at_neg();
    comb = 1; xs_lo = 2'b00; mask = 16'h00F0; pt_lo = 16'h0F00; #0.2;
    expect_v(0, 1'b0, "R1 masked terms");
    pt_lo = 16'h0020; #0.2;
    expect_v(0, 1'b1, "R1 single live term");
    mask = '0; pt_lo = '1; #0.2;
    expect_v(0, 1'b0, "R1 zero mask");
    xs_lo = 2'b01; #0.2;
    expect_v(0, 1'b1, "R4 complement");
    mask = '1; #0.2;
    expect_v(0, 1'b0, "R4 complement of 1");

    // R11: registered view differs from the XOR result
    hold_clear(); drop_clear();
    at_neg();
    comb = 0; xs_lo = 2'b00; pt_lo = 16'h8000; #0.2;
    expect_v(0, 1'b0, "R11 registered view");
    comb = 1; #0.2;
    expect_v(0, 1'b1, "R11 comb view");

    // R2, R3 carry path
    pt_lo = '0; xs_lo = 2'b10; cpt_lo = 2'b10; chain_lo = 1; cin_lo = 1; #0.2;
    expect_v(1, 1'b1, "R2 carry picks cpt1");
    expect_v(0, 1'b1, "R4 local carry operand");
    cin_lo = 0; #0.2;
    expect_v(1, 1'b0, "R2 carry picks cpt0");
    chain_lo = 0; cin_lo = 1; #0.2;
    expect_v(1, 1'b0, "R3 cut chain carry");
    expect_v(0, 1'b0, "R3 cut chain out");
    cpt_lo = 2'b01; #0.2;
    expect_v(1, 1'b1, "R3 cut chain gives cpt0");
    cpt_lo = 2'b00; cin_lo = 0; xs_lo = 2'b00;

    // R6: global clock 2
    comb = 0; hold_clear();
    csel = 3'd2; gx = '0; drop_clear();
    pt_lo = 16'h0001;
    tick();
    expect_v(0, 1'b0, "R6 gclk0 not selected");
    gx[2] = 1; #0.5;
    expect_v(0, 1'b1, "R6 gclk2 edge");
    // R6: product-term clock, code 4 and code 7
    hold_clear(); gx = '0; pt_clk = 0; csel = 3'd4; drop_clear();
    tick();
    expect_v(0, 1'b0, "R6 ptclk idle");
    pt_clk = 1; #0.5;
    expect_v(0, 1'b1, "R6 ptclk code 4");
    hold_clear(); pt_clk = 0; csel = 3'd7; drop_clear();
    pt_clk = 1; #0.5;
    expect_v(0, 1'b1, "R6 ptclk code 7");
    hold_clear(); pt_clk = 0; csel = 3'd0;

    // R7: falling-edge capture
    cfall = 1;
    at_neg(); drop_clear();
    tick();
    expect_v(0, 1'b0, "R7 rising edge ignored");
    @(negedge clk); #0.5;
    expect_v(0, 1'b1, "R7 falling edge capture");
    hold_clear(); cfall = 0;

    // R5: single-cell toggle
    xs_lo = 2'b11; pt_lo = 16'h0001;
    at_neg(); drop_clear();
    tick(); expect_v(0, 1'b1, "R5 toggle 1");
    tick(); expect_v(0, 1'b0, "R5 toggle 2");
    tick(); expect_v(0, 1'b1, "R5 toggle 3");
    pt_lo = '0;
    tick(); expect_v(0, 1'b1, "R5 hold when sum 0");

    // R5: two-cell counter
    hold_clear();
    xs_lo = 2'b11; xs_hi = 2'b11; pt_lo = 16'h0001; hi_fb = 1;
    at_neg(); drop_clear();
    for (int n = 1; n <= 5; n++) begin
      tick();
      expect_v(0, n[0], "R5 counter bit0");
      expect_v(2, n[1], "R5 counter bit1");
    end

    // R2, R4: adder slice over all operand combinations
    hold_clear(); drop_clear();
    hi_fb = 0; comb = 1; xs_lo = 2'b00; xs_hi = 2'b10;
    chain_lo = 1; chain_hi = 1; cpt_hi = 2'b10;
    for (int v = 0; v < 32; v++) begin
      logic a0, b0, a1, b1, c0, c1;
      {c0, a1, b1, a0, b0} = 5'(v);
      c1 = (a0 & b0) | (c0 & (a0 | b0));
      at_neg();
      cin_lo = c0;
      cpt_lo = {a0 | b0, a0 & b0};
      pt_lo = {12'b0, a0 & b0 & c0, a0 & ~b0 & ~c0, ~a0 & b0 & ~c0, ~a0 & ~b0 & c0};
      pt_hi_drv = {14'b0, ~a1 & b1, a1 & ~b1};
      #0.2;
      expect_v(0, a0 ^ b0 ^ c0, "R4 adder sum0");
      expect_v(1, c1, "R2 adder carry");
      expect_v(2, a1 ^ b1 ^ c1, "R4 adder sum1");
    end
    // R3: broken chain in the adder slice
    at_neg();
    cin_lo = 1; cpt_lo = 2'b10; pt_hi_drv = 16'h0001; chain_hi = 0; #0.2;
    expect_v(2, 1'b1, "R3 broken chain ignores carry");

    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule